// File: doc/BRIEF.md
# Prescaled I2C Bus Master

This block is a single-master I2C controller that sits behind a small register port. The system clock is divided by a programmable prescaler into a slower module tick. The SCL low and high phases are then timed in module ticks from two separate count registers, and a fixed offset of five ticks is added to each. Software programs the bare 7-bit target address and a byte count. It then issues a mode word that asks for a START. The controller sends the address byte with the direction bit filled in from the mode, moves the requested number of data bytes with ACK handling, and ends with STOP.

Writes are paced through a one-byte transmit holding register. If the next byte has not been written when it is needed, the controller holds SCL low until it arrives. Reads return each received byte through the receive register. The controller ACKs every received byte except the last, which it NACKs before STOP. A missing ACK from the target ends the transfer early, sets a NACK flag and issues STOP. The engine stays idle until the run bit of the mode word has been set by an earlier write.

Top module: `i2c_prescaled_master`

## Requirements
- R1: After reset the bus is released (SCL and SDA high), busy, receive-ready and NACK are 0, and transmit-ready is 1. Writing a mode word with the run bit (bit 5) clear returns the engine to idle and releases the bus.
- R2: The module tick repeats every PSC+1 clocks. Inside a transfer, each SCL low phase lasts (LOW+5)*(PSC+1) clocks and each SCL high phase lasts (HIGH+5)*(PSC+1) clocks. Register offsets are: 0 prescaler PSC, 1 low count, 2 high count, 3 target address, 4 byte count, 5 mode, 6 transmit data, 7 receive data.
- R3: Each transfer begins with SDA falling while SCL is high and ends with SDA rising while SCL is high. These are the only two SDA changes made while SCL is high.
- R4: The first byte on the bus is the 7-bit address register value shifted left by one, with bit 0 set to 1 for a read and 0 for a write. It is sent MSB first.
- R5: In a write, exactly the programmed count of bytes is sent MSB first, and then STOP follows. A count of 0 sends only the address before STOP.
- R6: In a read, the programmed count of bytes is received. The master drives SDA low in the ACK slot of every byte except the last, where it leaves SDA high. Each byte can be read from offset 7.
- R7: If SDA is high in the ACK slot after the address or after a written data byte, the NACK output becomes 1, no further byte is moved, and STOP is issued. NACK is cleared by the next START request.
- R8: Transmit-ready becomes 1 when the engine takes the holding byte and becomes 0 when offset 6 is written. While it is 1 and another write byte is due, SCL is held low. Receive-ready becomes 1 when a byte arrives and becomes 0 when offset 7 is read.
- R9: Busy is 1 from the cycle after an accepted START request until STOP completes. While busy is 0, SCL and SDA stay high.
- R10: A START is requested by a mode write with bit 13 (start), bit 10 (master) and bit 5 (run) all set. Bit 9 selects transmit (1) or receive (0). The request is ignored unless run was already set before that write, the master bit is set, and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive-ready on offset 7) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| scl_o | output | 1 | SCL level, 0 means pull low |
| sda_o | output | 1 | SDA level driven by the master, 0 means pull low |
| sda_i | input | 1 | Sampled SDA bus level |
| busy_o | output | 1 | Transfer in progress |
| tx_rdy_o | output | 1 | Transmit holding register empty |
| rx_rdy_o | output | 1 | Received byte waiting |
| nack_o | output | 1 | Target failed to acknowledge |

## Verification
The hardest case to reach is the held SCL-low stall. In that case the engine has finished a written byte while the transmit holding register is still empty, so the phase timing is suspended partway through a transfer. The bench reaches it by deliberately delaying the second byte of a write. It checks that SCL stays low and that the late byte still goes out intact. Early termination is reached with a bus-target model that NACKs a chosen address or data byte. Random prescaler and count values drive the phase-length checks, and one transfer uses the slow-clock, fast-mode setting.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int PAD_TICKS = 5;

    typedef enum logic [2:0] {
        REG_PSC  = 3'd0,
        REG_LOW  = 3'd1,
        REG_HIGH = 3'd2,
        REG_SADR = 3'd3,
        REG_CNT  = 3'd4,
        REG_MODE = 3'd5,
        REG_TXD  = 3'd6,
        REG_RXD  = 3'd7
    } reg_sel_e;

    localparam int MB_START  = 13;
    localparam int MB_MASTER = 10;
    localparam int MB_TX     = 9;
    localparam int MB_RUN    = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_BLO, ST_BHI, ST_HOLD, ST_PLO, ST_PHI, ST_PEND
    } eng_st_e;

    typedef enum logic [1:0] {FR_ADDR, FR_TXD, FR_RXD} frame_e;

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rx);
        return {a, rx};
    endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] psc,
    output logic          tick
);
    logic [PW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q >= psc);
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int TW  = 8,
    parameter int CW  = 8,
    parameter int PAD = PAD_TICKS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic          go,
    input  logic          rx_mode,
    input  logic [6:0]    sadr,
    input  logic [CW-1:0] nbytes,
    input  logic [TW-1:0] lo_cnt,
    input  logic [TW-1:0] hi_cnt,
    input  logic [7:0]    tx_byte,
    input  logic          tx_full,
    input  logic          sda_i,
    output logic          scl_o,
    output logic          sda_o,
    output logic          busy,
    output logic          tx_take,
    output logic          rx_done,
    output logic          nack_set,
    output logic [7:0]    rx_byte,
    output eng_st_e       st_o
);
    localparam int LW = TW + 1;

    eng_st_e       st_q;
    frame_e        fr_q;
    logic [LW-1:0] ph_q, lim;
    logic [3:0]    bit_q;
    logic [7:0]    sh_q;
    logic [CW-1:0] left_q;
    logic          rxm_q, sda_q, cur_bit, pend, frame_end, go_stop, go_next, last_one;

    assign lim = (st_q == ST_BLO || st_q == ST_PLO) ? ({1'b0, lo_cnt} + LW'(PAD))
                                                    : ({1'b0, hi_cnt} + LW'(PAD));
    assign pend      = tick && (ph_q == lim - 1'b1);
    assign last_one  = (left_q == CW'(1));
    assign frame_end = (st_q == ST_BHI) && pend && (bit_q == 4'd8);
    assign go_stop   = frame_end && ((fr_q == FR_RXD) ? last_one
                        : (sda_i || ((fr_q == FR_ADDR) ? (left_q == '0) : last_one)));
    assign go_next   = frame_end && !go_stop;
    assign nack_set  = frame_end && (fr_q != FR_RXD) && sda_i;
    assign rx_done   = frame_end && (fr_q == FR_RXD);
    assign tx_take   = tx_full && ((go_next && !rxm_q) || (st_q == ST_HOLD));

    always_comb begin
        if (bit_q != 4'd8) cur_bit = (fr_q == FR_RXD) ? 1'b1 : sh_q[7];
        else               cur_bit = (fr_q == FR_RXD) ? last_one : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q <= ST_IDLE;  fr_q <= FR_ADDR; ph_q <= '0;  bit_q <= '0;
            sh_q <= '0;       left_q <= '0;    rxm_q <= 1'b0; sda_q <= 1'b1;
            rx_byte <= '0;
        end else begin
            if (tick) ph_q <= ph_q + 1'b1;
            unique case (st_q)
                ST_IDLE: begin
                    sda_q <= 1'b1;
                    if (go) begin
                        st_q <= ST_START; ph_q <= '0; fr_q <= FR_ADDR; bit_q <= '0;
                        sh_q <= addr_byte(sadr, rx_mode); left_q <= nbytes; rxm_q <= rx_mode;
                    end
                end
                ST_START: begin
                    sda_q <= 1'b0;
                    if (pend) begin st_q <= ST_BLO; ph_q <= '0; end
                end
                ST_BLO: begin
                    sda_q <= cur_bit;
                    if (pend) begin st_q <= ST_BHI; ph_q <= '0; end
                end
                ST_BHI: begin
                    if (pend) begin
                        ph_q <= '0;
                        if (bit_q != 4'd8) begin
                            sh_q  <= {sh_q[6:0], sda_i};
                            bit_q <= bit_q + 1'b1;
                            st_q  <= ST_BLO;
                        end else begin
                            bit_q <= '0;
                            if (fr_q != FR_ADDR) left_q <= left_q - 1'b1;
                            if (fr_q == FR_RXD)  rx_byte <= sh_q;
                            if (go_stop) st_q <= ST_PLO;
                            else if (rxm_q) begin
                                fr_q <= FR_RXD; sh_q <= '0; st_q <= ST_BLO;
                            end else begin
                                fr_q <= FR_TXD;
                                if (tx_full) begin sh_q <= tx_byte; st_q <= ST_BLO; end
                                else st_q <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (tx_full) begin sh_q <= tx_byte; st_q <= ST_BLO; ph_q <= '0; end
                end
                ST_PLO: begin
                    sda_q <= 1'b0;
                    if (pend) begin st_q <= ST_PHI; ph_q <= '0; end
                end
                ST_PHI: begin
                    if (pend) begin st_q <= ST_PEND; ph_q <= '0; end
                end
                ST_PEND: begin
                    sda_q <= 1'b1;
                    if (pend) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign scl_o = !(st_q == ST_BLO || st_q == ST_HOLD || st_q == ST_PLO);
    assign sda_o = sda_q;
    assign busy  = (st_q != ST_IDLE);
    assign st_o  = st_q;
endmodule

// File: rtl/i2c_prescaled_master.sv
module i2c_prescaled_master
    import i2cm_pkg::*;
#(
    parameter int DW = 16,
    parameter int PW = 8,
    parameter int TW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          scl_o,
    output logic          sda_o,
    input  logic          sda_i,
    output logic          busy_o,
    output logic          tx_rdy_o,
    output logic          rx_rdy_o,
    output logic          nack_o
);
    logic [PW-1:0] psc_q;
    logic [TW-1:0] lo_q, hi_q;
    logic [6:0]    sadr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] mode_q;
    logic [7:0]    txd_q, rx_byte;
    logic          run, tick, go, wr_mode, tx_take, rx_done, nack_set;
    eng_st_e       eng_st;

    assign run     = mode_q[MB_RUN];
    assign wr_mode = reg_wr && (reg_addr == REG_MODE);
    assign go      = wr_mode && run && reg_wdata[MB_START] && reg_wdata[MB_MASTER]
                     && reg_wdata[MB_RUN];

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q <= '0; lo_q <= '0; hi_q <= '0; sadr_q <= '0;
            cnt_q <= '0; mode_q <= '0; txd_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel_e'(reg_addr))
                REG_PSC:  psc_q  <= reg_wdata[PW-1:0];
                REG_LOW:  lo_q   <= reg_wdata[TW-1:0];
                REG_HIGH: hi_q   <= reg_wdata[TW-1:0];
                REG_SADR: sadr_q <= reg_wdata[6:0];
                REG_CNT:  cnt_q  <= reg_wdata[CW-1:0];
                REG_MODE: mode_q <= reg_wdata;
                REG_TXD:  txd_q  <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tx_rdy_o <= 1'b1; rx_rdy_o <= 1'b0; nack_o <= 1'b0;
        end else begin
            if (tx_take) tx_rdy_o <= 1'b1;
            if (reg_wr && reg_addr == REG_TXD) tx_rdy_o <= 1'b0;
            if (reg_rd && reg_addr == REG_RXD) rx_rdy_o <= 1'b0;
            if (rx_done) rx_rdy_o <= 1'b1;
            if (go) nack_o <= 1'b0;
            if (nack_set) nack_o <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            REG_PSC:  reg_rdata = DW'(psc_q);
            REG_LOW:  reg_rdata = DW'(lo_q);
            REG_HIGH: reg_rdata = DW'(hi_q);
            REG_SADR: reg_rdata = DW'(sadr_q);
            REG_CNT:  reg_rdata = DW'(cnt_q);
            REG_MODE: reg_rdata = mode_q;
            REG_TXD:  reg_rdata = DW'(txd_q);
            default:  reg_rdata = DW'(rx_byte);
        endcase
    end

    i2cm_tick #(.PW(PW)) tick_i (
        .clk(clk), .rst(rst), .en(run), .psc(psc_q), .tick(tick)
    );

    i2cm_engine #(.TW(TW), .CW(CW)) eng_i (
        .clk(clk), .rst(rst), .en(run), .tick(tick), .go(go),
        .rx_mode(!reg_wdata[MB_TX]), .sadr(sadr_q), .nbytes(cnt_q),
        .lo_cnt(lo_q), .hi_cnt(hi_q), .tx_byte(txd_q), .tx_full(!tx_rdy_o),
        .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .busy(busy_o),
        .tx_take(tx_take), .rx_done(rx_done), .nack_set(nack_set),
        .rx_byte(rx_byte), .st_o(eng_st)
    );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    scl_o,
    input logic    sda_o,
    input logic    busy_o,
    input logic    nack_o,
    input logic    rx_rdy_o,
    input logic    reg_rd,
    input logic [2:0] reg_addr,
    input logic    rx_done,
    input logic    run,
    input eng_st_e st
);
    // R3
    sda_still_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BHI && $past(st) == ST_BHI) |-> $stable(sda_o));

    // R1
    run_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !busy_o);

    // R9
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (scl_o && sda_o));

    // R7
    nack_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nack_o) |-> (busy_o && !scl_o));

    // R8
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == REG_RXD && !rx_done && run) |=> !rx_rdy_o);
endmodule

bind i2c_prescaled_master i2cm_chk chk_i (
    .clk(clk), .rst(rst), .scl_o(scl_o), .sda_o(sda_o), .busy_o(busy_o),
    .nack_o(nack_o), .rx_rdy_o(rx_rdy_o), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .rx_done(rx_done), .run(run), .st(eng_st)
);

// File: tb/i2c_prescaled_master_tb_top.sv
module i2c_prescaled_master_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_s = 1'b0, rd_s = 1'b0;
    logic [2:0]  addr_s = '0;
    logic [15:0] wdata_s = '0;
    logic [15:0] rdata;
    logic scl_o, sda_o, sda_i, busy_o, tx_rdy_o, rx_rdy_o, nack_o;
    logic sl_drv = 1'b1;

    always #2 clk = ~clk;
    assign sda_i = sda_o & sl_drv;

    i2c_prescaled_master dut_i (
        .clk(clk), .rst(rst), .reg_wr(wr_s), .reg_rd(rd_s), .reg_addr(addr_s),
        .reg_wdata(wdata_s), .reg_rdata(rdata), .scl_o(scl_o), .sda_o(sda_o),
        .sda_i(sda_i), .busy_o(busy_o), .tx_rdy_o(tx_rdy_o), .rx_rdy_o(rx_rdy_o),
        .nack_o(nack_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_pat(input int i);
        return 8'hA5 ^ 8'(i * 37);
    endfunction

    // bus target model and phase timing monitor
    logic [6:0] sl_match = '0;
    int   nack_at = -1;
    int   bitc = 0, byt = 0, n_wr = 0, n_start = 0, n_stop = 0, n_hichg = 0;
    bit   act = 0, rw = 0, sl_done = 0, ps = 1, pd = 1;
    logic [7:0] shreg = '0, adr_seen = '0, tmp;
    logic [7:0] wr_cap [16];
    bit   mack [16];
    bit   tim_on = 0, tim_skip = 1;
    int   t_psc = 0, t_lo = 0, t_hi = 0, rise_t = -1, fall_t = -1;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (ps && scl_o && (pd != sda_i)) n_hichg++;
        if (ps && scl_o && pd && !sda_i) begin
            act = 1; bitc = -1; byt = 0; sl_done = 0; sl_drv = 1; n_start++; tim_skip = 1;
        end else if (ps && scl_o && !pd && sda_i) begin
            act = 0; sl_drv = 1; n_stop++; tim_skip = 1;
        end else if (!ps && scl_o) begin
            if (act) begin
                if (bitc < 8) shreg = {shreg[6:0], sda_i};
                else if (rw && byt > 0) begin
                    mack[byt-1] = sda_i;
                    if (sda_i) sl_done = 1;
                end
            end
            // R2 low phase length
            if (tim_on && fall_t >= 0) chk("R2 low", cyc - fall_t, (t_lo + 5) * (t_psc + 1));
            rise_t = cyc; tim_skip = 0;
        end else if (ps && !scl_o) begin
            if (act) begin
                if (bitc == 8) begin bitc = 0; byt++; end else bitc++;
                if (bitc == 8) begin
                    if (byt == 0) begin
                        adr_seen = shreg; rw = shreg[0];
                        sl_drv = !((shreg[7:1] == sl_match) && nack_at != 0);
                        if (sl_drv) sl_done = 1;
                    end else if (!rw) begin
                        wr_cap[n_wr] = shreg; n_wr++;
                        sl_drv = (nack_at == byt);
                    end else sl_drv = 1;
                end else if (rw && byt > 0 && !sl_done) begin
                    tmp = rd_pat(byt - 1); sl_drv = tmp[7 - bitc];
                end else sl_drv = 1;
            end
            // R2 high phase length
            if (tim_on && !tim_skip && rise_t >= 0)
                chk("R2 high", cyc - rise_t, (t_hi + 5) * (t_psc + 1));
            fall_t = cyc;
        end
        ps = scl_o; pd = sda_i;
    end

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        addr_s = a; wdata_s = d; wr_s = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_s = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        addr_s = a; rd_s = 1'b1; #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_s = 1'b0;
    endtask

    task automatic do_xfer(input bit rx, input logic [6:0] sa, input int n, input int psc,
                           input int lo, input int hi, input int nk, input bit mism,
                           input bit stall);
        logic [7:0]  data [16];
        logic [15:0] rv;
        int n_rd = 0, st0, sp0;
        bit anack;
        sl_match = mism ? (sa ^ 7'h55) : sa; nack_at = nk;
        n_wr = 0; adr_seen = '0; n_hichg = 0; st0 = n_start; sp0 = n_stop;
        for (int i = 0; i < 16; i++) mack[i] = 0;
        t_psc = psc; t_lo = lo; t_hi = hi; tim_on = !stall;
        reg_wr(3'd0, 16'(psc)); reg_wr(3'd1, 16'(lo)); reg_wr(3'd2, 16'(hi));
        reg_wr(3'd3, 16'(sa));  reg_wr(3'd4, 16'(n));  reg_wr(3'd5, 16'h0020);
        if (!rx && n > 0) begin
            data[0] = 8'($urandom);
            reg_wr(3'd6, 16'(data[0]));
            chk("R8 tx_rdy cleared by write", tx_rdy_o, 0);
        end
        reg_wr(3'd5, rx ? 16'h2420 : 16'h2620);
        chk("R9 busy after start", busy_o, 1);
        chk("R7 nack cleared on start", nack_o, 0);
        if (!rx) begin
            for (int i = 1; i < n; i++) begin
                while (!(tx_rdy_o || !busy_o)) @(negedge clk);
                if (!busy_o) break;
                if (stall && i == 1) begin
                    repeat (250) @(negedge clk);
                    chk("R8 SCL held low while empty", {busy_o, scl_o}, 2'b10);
                end
                data[i] = 8'($urandom);
                reg_wr(3'd6, 16'(data[i]));
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                while (!(rx_rdy_o || !busy_o)) @(negedge clk);
                if (!rx_rdy_o) break;
                reg_rd(3'd7, rv);
                chk("R6 received byte", rv[7:0], rd_pat(i));
                chk("R8 rx_rdy cleared by read", rx_rdy_o, 0);
                n_rd++;
            end
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        tim_on = 0;
        anack = mism || (nk == 0);
        chk("R4 address byte", adr_seen, {sa, rx});
        chk("R3 one START", n_start - st0, 1);
        chk("R3 one STOP", n_stop - sp0, 1);
        chk("R3 SDA changes with SCL high", n_hichg, 2);
        chk("R9 bus released when idle", {busy_o, scl_o, sda_o}, 3'b011);
        if (rx) begin
            chk("R7 nack flag (read)", nack_o, anack);
            chk("R6 bytes received", n_rd, anack ? 0 : n);
            if (!anack) for (int i = 0; i < n; i++) chk("R6 master ack slot", mack[i], i == n - 1);
        end else begin
            chk("R7 nack flag (write)", nack_o, anack || (nk >= 1 && nk <= n));
            chk("R5 bytes sent", n_wr, anack ? 0 : ((nk >= 1 && nk <= n) ? nk : n));
            for (int i = 0; i < n_wr; i++) chk("R5 byte value", wr_cap[i], data[i]);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] rv;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset bus", {scl_o, sda_o}, 2'b11);
        chk("R1 reset flags", {busy_o, tx_rdy_o, rx_rdy_o, nack_o}, 4'b0100);
        reg_rd(3'd5, rv);
        chk("R1 mode after reset", rv, 0);
        // R10 start while run not yet set is ignored
        reg_wr(3'd4, 16'd1);
        reg_wr(3'd5, 16'h2620);
        repeat (40) @(negedge clk);
        chk("R10 start ignored before run", {busy_o, scl_o, sda_o}, 3'b011);
        // R10 start without master bit is ignored
        reg_wr(3'd5, 16'h2220);
        repeat (40) @(negedge clk);
        chk("R10 start ignored without master", {busy_o, scl_o, sda_o}, 3'b011);
        // fast-mode setting, address 0x21 read then write
        do_xfer(1, 7'h21, 1, 14, 7, 8, -1, 0, 0);
        do_xfer(0, 7'h21, 1, 0, 0, 0, -1, 0, 0);
        // R5 count zero
        do_xfer(0, 7'h3C, 0, 1, 2, 1, -1, 0, 0);
        // R7 address NACK (write and read), data NACK on byte 2
        do_xfer(0, 7'h50, 3, 0, 1, 2, -1, 1, 0);
        do_xfer(1, 7'h11, 2, 1, 0, 0, 0, 0, 0);
        do_xfer(0, 7'h6A, 4, 0, 2, 0, 2, 0, 0);
        // R8 stall while holding register is empty
        do_xfer(0, 7'h2B, 2, 0, 1, 1, -1, 0, 1);
        // random mix
        for (int k = 0; k < 16; k++) begin
            bit rx = 1'($urandom);
            int nk = (!rx && ($urandom % 4 == 0)) ? 1 + int'($urandom % 4) : -1;
            do_xfer(rx, 7'($urandom), 1 + int'($urandom % 4), int'($urandom % 4),
                    int'($urandom % 5), int'($urandom % 5), nk, 0, 0);
        end
        // R1 disable mid-transfer
        reg_wr(3'd4, 16'd3);
        reg_wr(3'd6, 16'h00C3);
        reg_wr(3'd5, 16'h2620);
        repeat (60) @(negedge clk);
        chk("R9 busy mid-transfer", busy_o, 1);
        reg_wr(3'd5, 16'h0000);
        @(negedge clk);
        chk("R1 disable releases bus", {busy_o, scl_o, sda_o}, 3'b011);
        chk("R1 disable clears flags", {tx_rdy_o, rx_rdy_o, nack_o}, 3'b100);
        act = 0;
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule